// File: doc/BRIEF.md
# Idle and power-down mode controller

This block decides, cycle by cycle, which clocks of a small 8-bit microcontroller run and when its core is held in reset. Software asks for a low-power mode by writing a control word with an idle bit and a power-down bit. In idle, the processor clock stops while the peripheral clock keeps running, so timers, the serial port, interrupt logic and RAM keep working. In power-down, the oscillator enable drops, which freezes every function. The block sits in the always-on domain and is clocked by the raw oscillator.

Any enabled pending interrupt ends idle. The hardware reset pin ends idle or power-down, and nothing else ends power-down. A reset that ends idle first opens a short grace window. In that window the processor keeps running for two machine cycles (twelve oscillator periods each) while RAM writes are inhibited. Port writes are not blocked in that window. After that the internal reset takes over. The internal reset stays asserted until the pin is released and the oscillator reports stable. It is then held for a further programmable number of oscillator cycles before it is released.

The request bits read back as two flags. Each flag sets when its mode is entered and clears by itself when that mode is left.

Top module: `lpm_ctrl`

## Requirements
- R1: After the block reset `rst_n` is released, the controller is in the reset-hold state: `core_rst`=1, `ram_wr_inh`=1, `mode_o`=3, and both clock enables and `osc_en` are 1. `core_rst` falls exactly HOLD_CYC cycles after the first clock edge at which `osc_stable`=1 and `rst_pin`=0, and from then on `mode_o`=0 (run).
- R2: In run, a write (`ctl_we`=1) with `ctl_idle`=1 and `ctl_pd`=0 gives, from the next cycle on: `cpu_clk_en`=0, `per_clk_en`=1, `osc_en`=1, `mode_o`=1 and `idle_flag`=1.
- R3: In idle, any nonzero bit of `irq_pend` with `rst_pin`=0 returns the block to run on the next cycle (`mode_o`=0, `cpu_clk_en`=1), and `idle_flag` clears.
- R4: In run, a write with `ctl_pd`=1 gives, from the next cycle on: `osc_en`=0, `cpu_clk_en`=0, `per_clk_en`=0, `mode_o`=2 and `pd_flag`=1.
- R5: A write with both `ctl_idle` and `ctl_pd` set enters power-down, not idle, and `idle_flag` stays 0.
- R6: In power-down, `irq_pend` has no effect. Only `rst_pin`=1 leaves it, going on the next cycle to reset-hold (`core_rst`=1, `osc_en`=1, `mode_o`=3), and `pd_flag` clears.
- R7: `rst_pin`=1 in idle opens a window of OSC_PER_MC*WIN_MC cycles (24 by default). In that window `cpu_clk_en`=1, `core_rst`=0, `ram_wr_inh`=1 and `mode_o`=3. Reset-hold follows it.
- R8: In reset-hold, `core_rst` stays 1 for as long as `rst_pin`=1 or `osc_stable`=0. Any such cycle restarts the HOLD_CYC count.
- R9: `ram_wr_inh` is 1 in the window and in reset-hold, and 0 in run, idle and power-down.
- R10: Control writes outside run are ignored: mode and flags are unchanged. `rst_pin`=1 in run goes to reset-hold on the next cycle.
- R11: In idle, `rst_pin`=1 takes priority over a pending interrupt in the same cycle: the window opens and the block does not return to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock of the always-on domain |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| ctl_we | input | 1 | Control word write strobe |
| ctl_idle | input | 1 | Idle request bit of the written word |
| ctl_pd | input | 1 | Power-down request bit of the written word |
| irq_pend | input | N_IRQ | Enabled pending interrupts, already synchronous |
| rst_pin | input | 1 | Hardware reset pin, active high, already synchronous |
| osc_stable | input | 1 | Oscillator has restarted and is stable |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| per_clk_en | output | 1 | Peripheral, interrupt and RAM clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Internal reset to the core, active high |
| ram_wr_inh | output | 1 | Internal RAM write inhibit |
| mode_o | output | 2 | 0 run, 1 idle, 2 power-down, 3 reset sequencing |
| idle_flag | output | 1 | Idle request bit readback |
| pd_flag | output | 1 | Power-down request bit readback |

## Verification
Some rules hold on every cycle, and the assertions check them there:
- power-down wins over idle;
- power-down ignores interrupts;
- an interrupt ends idle unless the reset pin is high at the same time;
- a stopped oscillator means both gates are off;
- the internal reset only falls after a stable, reset-free cycle;
- the flags are never both set and the counter stays in range.

Other behaviour only shows up in the bench's scenarios, where a cycle model runs next to the block:
- the exact window length of twenty-four cycles;
- the exact hold length, counted from the stable-oscillator edge;
- the restart of that count when the oscillator drops;
- writes that are ignored outside run.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_PDOWN = 3'd2,
    ST_RWIN  = 3'd3,
    ST_RHOLD = 3'd4
  } lpm_state_e;

  localparam logic [1:0] MODE_RUN   = 2'd0;
  localparam logic [1:0] MODE_IDLE  = 2'd1;
  localparam logic [1:0] MODE_PDOWN = 2'd2;
  localparam logic [1:0] MODE_RESET = 2'd3;

endpackage

// File: rtl/lpm_rstsync.sv
module lpm_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/lpm_cnt.sv
module lpm_cnt #(
  parameter int W    = 6,
  parameter int MAXV = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < W'(MAXV));
endmodule

// File: rtl/lpm_reqreg.sv
module lpm_reqreg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_idle,
  input  logic set_pd,
  input  logic clr_flags,
  output logic idle_flag,
  output logic pd_flag
);
  logic idle_d, pd_d;

  always_comb begin
    idle_d = idle_flag;
    pd_d   = pd_flag;
    if (clr_flags) begin
      idle_d = 1'b0;
      pd_d   = 1'b0;
    end else begin
      if (set_pd)   pd_d   = 1'b1;
      if (set_idle) idle_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_flag <= 1'b0;
      pd_flag   <= 1'b0;
    end else begin
      idle_flag <= idle_d;
      pd_flag   <= pd_d;
    end
  end

  assert_set_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_idle, set_pd}));
  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({idle_flag, pd_flag}));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int N_IRQ    = 6,
  parameter int CW       = 6,
  parameter int WIN_LEN  = 24,
  parameter int HOLD_LEN = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_idle,
  input  logic             ctl_pd,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic             rst_pin,
  input  logic             osc_stable,
  input  logic [CW-1:0]    cnt,
  output lpm_state_e       state,
  output logic             cnt_clr,
  output logic             cnt_inc,
  output logic             set_idle,
  output logic             set_pd,
  output logic             clr_flags
);
  localparam logic [CW-1:0] WIN_LAST  = CW'(WIN_LEN - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_LEN - 1);

  lpm_state_e state_d;
  logic       irq_any;

  assign irq_any = |irq_pend;

  always_comb begin
    state_d   = state;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    set_idle  = 1'b0;
    set_pd    = 1'b0;
    clr_flags = 1'b0;
    unique case (state)
      ST_RUN: begin
        cnt_clr = 1'b1;
        if (rst_pin) begin
          state_d   = ST_RHOLD;
          clr_flags = 1'b1;
        end else if (ctl_we && ctl_pd) begin
          state_d = ST_PDOWN;
          set_pd  = 1'b1;
        end else if (ctl_we && ctl_idle) begin
          state_d  = ST_IDLE;
          set_idle = 1'b1;
        end
      end
      ST_IDLE: begin
        cnt_clr = 1'b1;
        if (rst_pin) begin
          state_d   = ST_RWIN;
          clr_flags = 1'b1;
        end else if (irq_any) begin
          state_d   = ST_RUN;
          clr_flags = 1'b1;
        end
      end
      ST_PDOWN: begin
        cnt_clr = 1'b1;
        if (rst_pin) begin
          state_d   = ST_RHOLD;
          clr_flags = 1'b1;
        end
      end
      ST_RWIN: begin
        if (cnt == WIN_LAST) begin
          state_d = ST_RHOLD;
          cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_RHOLD: begin
        if (rst_pin || !osc_stable) begin
          cnt_clr = 1'b1;
        end else if (cnt == HOLD_LAST) begin
          state_d = ST_RUN;
          cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: begin
        state_d = ST_RHOLD;
        cnt_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RHOLD;
    else        state <= state_d;
  end

  assert_pd_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && ctl_we && ctl_pd && ctl_idle && !rst_pin) |=> state == ST_PDOWN);
  assert_pd_ignores_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PDOWN && !rst_pin) |=> state == ST_PDOWN);
  assert_idle_irq_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !rst_pin && irq_any) |=> state == ST_RUN);
  assert_idle_reset_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && rst_pin) |=> state == ST_RWIN);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int N_IRQ      = 6,
  parameter int OSC_PER_MC = 12,
  parameter int WIN_MC     = 2,
  parameter int HOLD_CYC   = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_idle,
  input  logic             ctl_pd,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic             rst_pin,
  input  logic             osc_stable,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             core_rst,
  output logic             ram_wr_inh,
  output logic [1:0]       mode_o,
  output logic             idle_flag,
  output logic             pd_flag
);
  localparam int WIN_LEN = OSC_PER_MC * WIN_MC;
  localparam int MAXC    = (WIN_LEN > HOLD_CYC) ? WIN_LEN : HOLD_CYC;
  localparam int CW      = $clog2(MAXC + 1);

  logic          rst_s_n;
  lpm_state_e    state;
  logic [CW-1:0] cnt;
  logic          cnt_clr, cnt_inc, set_idle, set_pd, clr_flags;

  lpm_rstsync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  lpm_fsm #(
    .N_IRQ(N_IRQ), .CW(CW), .WIN_LEN(WIN_LEN), .HOLD_LEN(HOLD_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .ctl_we(ctl_we), .ctl_idle(ctl_idle),
    .ctl_pd(ctl_pd), .irq_pend(irq_pend), .rst_pin(rst_pin),
    .osc_stable(osc_stable), .cnt(cnt), .state(state), .cnt_clr(cnt_clr),
    .cnt_inc(cnt_inc), .set_idle(set_idle), .set_pd(set_pd),
    .clr_flags(clr_flags)
  );

  lpm_cnt #(.W(CW), .MAXV(MAXC)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
  );

  lpm_reqreg u_req (
    .clk(clk), .rst_n(rst_s_n), .set_idle(set_idle), .set_pd(set_pd),
    .clr_flags(clr_flags), .idle_flag(idle_flag), .pd_flag(pd_flag)
  );

  always_comb begin
    cpu_clk_en = 1'b1;
    per_clk_en = 1'b1;
    osc_en     = 1'b1;
    core_rst   = 1'b0;
    ram_wr_inh = 1'b0;
    mode_o     = MODE_RUN;
    unique case (state)
      ST_IDLE: begin
        cpu_clk_en = 1'b0;
        mode_o     = MODE_IDLE;
      end
      ST_PDOWN: begin
        cpu_clk_en = 1'b0;
        per_clk_en = 1'b0;
        osc_en     = 1'b0;
        mode_o     = MODE_PDOWN;
      end
      ST_RWIN: begin
        ram_wr_inh = 1'b1;
        mode_o     = MODE_RESET;
      end
      ST_RHOLD: begin
        core_rst   = 1'b1;
        ram_wr_inh = 1'b1;
        mode_o     = MODE_RESET;
      end
      default: ;
    endcase
  end

  assert_osc_off_gates_off_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !osc_en |-> (!cpu_clk_en && !per_clk_en));
  assert_release_needs_stable_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(core_rst) |-> ($past(osc_stable) && !$past(rst_pin)));
  assert_reset_inhibits_ram_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    core_rst |-> ram_wr_inh);
  assert_idle_flag_mode_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(idle_flag) |-> (mode_o == MODE_IDLE && !cpu_clk_en && per_clk_en));
endmodule

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;
  localparam int NIRQ = 6;
  localparam int WINL = 24;
  localparam int HOLD = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0, ctl_idle = 1'b0, ctl_pd = 1'b0;
  logic [NIRQ-1:0] irq_pend = '0;
  logic rst_pin = 1'b0, osc_stable = 1'b0;
  logic cpu_clk_en, per_clk_en, osc_en, core_rst, ram_wr_inh;
  logic [1:0] mode_o;
  logic idle_flag, pd_flag;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model: 0 run, 1 idle, 2 power-down, 3 window, 4 hold
  int m_st = 4, m_cnt = 0;
  bit m_if = 0, m_pf = 0;

  lpm_ctrl #(.N_IRQ(NIRQ), .OSC_PER_MC(12), .WIN_MC(2), .HOLD_CYC(HOLD)) i_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_idle(ctl_idle), .ctl_pd(ctl_pd),
    .irq_pend(irq_pend), .rst_pin(rst_pin), .osc_stable(osc_stable),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .core_rst(core_rst), .ram_wr_inh(ram_wr_inh), .mode_o(mode_o),
    .idle_flag(idle_flag), .pd_flag(pd_flag)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    int ns, nc;
    bit nif, npf;
    ns = m_st; nc = m_cnt; nif = m_if; npf = m_pf;
    if (!rst_n) begin
      ns = 4; nc = 0; nif = 0; npf = 0;
    end else begin
      case (m_st)
        0: if (rst_pin) begin ns = 4; nc = 0; end
           else if (ctl_we && ctl_pd) begin ns = 2; npf = 1; end
           else if (ctl_we && ctl_idle) begin ns = 1; nif = 1; end
        1: if (rst_pin) begin ns = 3; nc = 0; nif = 0; end
           else if (irq_pend != 0) begin ns = 0; nif = 0; end
        2: if (rst_pin) begin ns = 4; nc = 0; npf = 0; end
        3: if (m_cnt == WINL - 1) begin ns = 4; nc = 0; end else nc = m_cnt + 1;
        default: if (rst_pin || !osc_stable) nc = 0;
                 else if (m_cnt == HOLD - 1) begin ns = 0; nc = 0; end
                 else nc = m_cnt + 1;
      endcase
    end
    m_st = ns; m_cnt = nc; m_if = nif; m_pf = npf;
  end

  function automatic logic [8:0] exp_pack(int st, bit fi, bit fp);
    logic [6:0] o;
    case (st)
      0: o = 7'b1110000;
      1: o = 7'b0110001;
      2: o = 7'b0000010;
      3: o = 7'b1110111;
      default: o = 7'b1111111;
    endcase
    return {o, fi, fp};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished)
      chk(cur_req, {23'd0, cpu_clk_en, per_clk_en, osc_en, core_rst, ram_wr_inh,
                    mode_o, idle_flag, pd_flag},
          {23'd0, exp_pack(m_st, m_if, m_pf)});
  end

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit i, bit p);
    ctl_we = 1; ctl_idle = i; ctl_pd = p;
    @(negedge clk);
    ctl_we = 0; ctl_idle = 0; ctl_pd = 0;
  endtask

  task automatic measure_hold(string req);
    int n = 0;
    do begin @(negedge clk); n++; end while (core_rst && n < 1000);
    chk(req, n, HOLD);
    chk(req, mode_o, 0);
  endtask

  initial begin
    ticks(4);
    rst_n = 1;
    ticks(6);
    cur_req = "R1";
    chk("R1", {core_rst, ram_wr_inh, mode_o}, 4'b1111);
    chk("R1", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    osc_stable = 1;
    measure_hold("R1");

    cur_req = "R2";
    wr(1, 0);
    chk("R2", {cpu_clk_en, per_clk_en, osc_en, mode_o, idle_flag}, 6'b011011);
    ticks(5);
    chk("R2", mode_o, 1);
    cur_req = "R10";
    wr(0, 1);
    chk("R10", {mode_o, pd_flag, idle_flag}, 4'b0101);
    cur_req = "R3";
    irq_pend = 6'b001000;
    @(negedge clk);
    irq_pend = '0;
    chk("R3", {mode_o, cpu_clk_en, idle_flag}, 4'b0010);

    cur_req = "R5";
    wr(1, 1);
    chk("R5", {mode_o, pd_flag, idle_flag, osc_en}, 5'b10100);
    cur_req = "R6";
    irq_pend = 6'b111111;
    ticks(4);
    irq_pend = '0;
    chk("R6", mode_o, 2);
    osc_stable = 0;
    rst_pin = 1;
    @(negedge clk);
    chk("R6", {core_rst, osc_en, mode_o, pd_flag}, 5'b11110);
    ticks(3);
    rst_pin = 0;
    cur_req = "R8";
    ticks(HOLD + 5);
    chk("R8", core_rst, 1);
    osc_stable = 1;
    ticks(10);
    osc_stable = 0;
    @(negedge clk);
    osc_stable = 1;
    measure_hold("R8");

    cur_req = "R4";
    wr(0, 1);
    chk("R4", {osc_en, cpu_clk_en, per_clk_en, mode_o, pd_flag}, 6'b000101);
    rst_pin = 1;
    @(negedge clk);
    rst_pin = 0;
    measure_hold("R4");

    cur_req = "R7";
    wr(1, 0);
    rst_pin = 1;
    begin
      int n = 0;
      @(negedge clk);
      while (mode_o == 3 && !core_rst && n < 1000) begin
        chk("R9", {ram_wr_inh, cpu_clk_en}, 2'b11);
        n++;
        @(negedge clk);
      end
      chk("R7", n, WINL);
      chk("R7", {core_rst, ram_wr_inh}, 2'b11);
    end
    ticks(3);
    rst_pin = 0;
    measure_hold("R7");
    chk("R9", ram_wr_inh, 0);

    cur_req = "R11";
    wr(1, 0);
    rst_pin = 1;
    irq_pend = 6'b000001;
    @(negedge clk);
    rst_pin = 0;
    irq_pend = '0;
    chk("R11", {mode_o, core_rst, ram_wr_inh}, 4'b1101);
    ticks(WINL);
    measure_hold("R11");

    cur_req = "R10";
    rst_pin = 1;
    @(negedge clk);
    chk("R10", {mode_o, core_rst}, 3'b111);
    wr(1, 0);
    chk("R10", {mode_o, idle_flag}, 3'b110);
    rst_pin = 0;
    measure_hold("R10");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule